// File: doc/BRIEF.md
# Divide Step Unit

This block performs one iteration of a non-restoring division in a single clock. On every cycle where the strobe is high and the divide-step extension is enabled, it does four things. It builds a partial remainder from the current Y value and the top bit of the dividend operand. It adds the divisor to that remainder or subtracts it, depending on the step sign carried in the N and V flags. It registers the new Y value, the four condition flags and a destination value that holds the next quotient bit. An outer sequencer calls it once per quotient bit and feeds the registered Y and flags back in for the next step. That sequencer, and any final remainder correction, lie outside this block.

Control is a small state register. It records what the last strobe did, and the one-cycle status outputs are decoded from it:
- `ST_IDLE`: no strobe in the previous cycle.
- `ST_STEP`: a step ran, and the destination index was zero.
- `ST_WRITE`: a step ran, and the destination value must be written.
- `ST_TRAP`: the strobe arrived while the extension was disabled.

Each cycle the state moves as follows:
- With no strobe, it moves to `ST_IDLE`.
- With a strobe and the extension enabled, it moves to `ST_WRITE` if the index is nonzero, or to `ST_STEP` if the index is zero.
- With a strobe and the extension disabled, it moves to `ST_TRAP`.

Top module: `dstep_unit`

## Requirements
- R1: After reset, y_o, rd_data_o and all four flag outputs are zero, and rd_wr_o and trap_o are low.
- R2: The step sign is n_in XOR v_in. The partial remainder is y_in shifted left by one, with rs1_in bit 31 moved into bit 0. When the sign is 0, the two's-complement negation of divisor_in is added to the remainder. When the sign is 1, divisor_in is added unchanged.
- R3: On the clock edge that samples an enabled strobe, y_o takes the 32-bit sum.
- R4: On that edge, n_o takes bit 31 of the sum.
- R5: z_o is set only when the sum is zero and the step sign equals bit 31 of the old y_in. Otherwise z_o is cleared.
- R6: c_o is set when the sum is unsigned-less-than either addend.
- R7: The new sign is (sign AND NOT y31) OR (NOT c AND (sign OR NOT y31)), where y31 is bit 31 of y_in and c is the carry of R6. v_o is set when the new sign differs from bit 31 of the sum.
- R8: When rd_idx is nonzero, rd_data_o becomes rs1_in shifted left by one with the inverted new sign in bit 0, and rd_wr_o is high for exactly the following cycle. When rd_idx is zero, rd_wr_o stays low and rd_data_o keeps its value.
- R9: A strobe with ext_en low raises trap_o for one cycle, and y_o, rd_data_o and the flags keep their values.
- R10: Without a strobe, all registered outputs hold and both status pulses are low. rd_wr_o and trap_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Divide-step strobe |
| ext_en | input | 1 | Divide-step extension enabled |
| y_in | input | 32 | Current Y value |
| rs1_in | input | 32 | Dividend / partial-quotient operand |
| divisor_in | input | 32 | Divisor operand |
| n_in | input | 1 | Current N flag |
| v_in | input | 1 | Current V flag |
| rd_idx | input | 5 | Destination register index |
| y_o | output | 32 | Registered new Y value |
| rd_data_o | output | 32 | Registered destination value |
| rd_wr_o | output | 1 | Destination write pulse |
| trap_o | output | 1 | Unimplemented-instruction trap pulse |
| n_o | output | 1 | New N flag |
| z_o | output | 1 | New Z flag |
| v_o | output | 1 | New V flag |
| c_o | output | 1 | New C flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and a 5-bit register index. At that width, the bench drives values such as 0x8000_0000, 0xFFFF_FFFF and a zero divisor into the adder. These reach both forms of the carry comparison, the case where the sum wraps to zero, and every combination of step sign with the Y top bit that decides the zero flag. A chain of steps with the outputs fed back tests the unit as a sequencer would drive it.

// File: rtl/dstep_pkg.sv
package dstep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TRAP  = 2'd3
    } dstep_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } dstep_flags_t;
endpackage

// File: rtl/dstep_addsub.sv
module dstep_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] y_in,
    input  logic [WIDTH-1:0] rs1_in,
    input  logic [WIDTH-1:0] divisor_in,
    input  logic             sign,
    output logic [WIDTH-1:0] sum,
    output logic             carry
);
    logic [WIDTH-1:0] remainder;
    logic [WIDTH-1:0] addend;

    always_comb begin
        remainder = {y_in[WIDTH-2:0], rs1_in[WIDTH-1]};
        addend    = sign ? divisor_in : (~divisor_in + {{(WIDTH-1){1'b0}}, 1'b1});
        sum       = remainder + addend;
        carry     = (sum < remainder) || (sum < addend);
    end
endmodule

// File: rtl/dstep_flags.sv
module dstep_flags
    import dstep_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sum,
    input  logic             carry,
    input  logic             sign,
    input  logic             y_msb,
    output dstep_flags_t     flags,
    output logic             new_sign
);
    always_comb begin
        new_sign = (sign && !y_msb) || (!carry && (sign || !y_msb));
        flags.n  = sum[WIDTH-1];
        flags.z  = (sum == '0) && (sign == y_msb);
        flags.v  = new_sign ^ sum[WIDTH-1];
        flags.c  = carry;
    end
endmodule

// File: rtl/dstep_unit.sv
module dstep_unit
    import dstep_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             ext_en,
    input  logic [WIDTH-1:0] y_in,
    input  logic [WIDTH-1:0] rs1_in,
    input  logic [WIDTH-1:0] divisor_in,
    input  logic             n_in,
    input  logic             v_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] y_o,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             rd_wr_o,
    output logic             trap_o,
    output logic             n_o,
    output logic             z_o,
    output logic             v_o,
    output logic             c_o
);
    localparam int MSB = WIDTH - 1;

    dstep_state_e     state_q, state_d;
    logic             step_sign;
    logic [WIDTH-1:0] sum;
    logic             carry;
    logic             new_sign;
    dstep_flags_t     flags_d;
    dstep_flags_t     flags_q;
    logic             do_step;

    assign step_sign = n_in ^ v_in;
    assign do_step   = step_en && ext_en;

    dstep_addsub #(.WIDTH(WIDTH)) u_addsub (
        .y_in       (y_in),
        .rs1_in     (rs1_in),
        .divisor_in (divisor_in),
        .sign       (step_sign),
        .sum        (sum),
        .carry      (carry)
    );

    dstep_flags #(.WIDTH(WIDTH)) u_flags (
        .sum      (sum),
        .carry    (carry),
        .sign     (step_sign),
        .y_msb    (y_in[MSB]),
        .flags    (flags_d),
        .new_sign (new_sign)
    );

    // next-state decode
    always_comb begin
        state_d = ST_IDLE;
        unique case ({step_en, ext_en})
            2'b11:   state_d = (rd_idx != '0) ? ST_WRITE : ST_STEP;
            2'b10:   state_d = ST_TRAP;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered data outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o       <= '0;
            rd_data_o <= '0;
            flags_q   <= '0;
        end else if (do_step) begin
            y_o     <= sum;
            flags_q <= flags_d;
            if (rd_idx != '0)
                rd_data_o <= {rs1_in[MSB-1:0], ~new_sign};
        end
    end

    // status decode from state
    always_comb begin
        rd_wr_o = 1'b0;
        trap_o  = 1'b0;
        unique case (state_q)
            ST_WRITE: rd_wr_o = 1'b1;
            ST_TRAP:  trap_o  = 1'b1;
            default:  ;
        endcase
    end

    assign n_o = flags_q.n;
    assign z_o = flags_q.z;
    assign v_o = flags_q.v;
    assign c_o = flags_q.c;
endmodule

// File: rtl/dstep_unit_chk.sv
module dstep_unit_chk #(
    parameter int WIDTH = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             ext_en,
    input logic [IDX_W-1:0] rd_idx,
    input logic [WIDTH-1:0] y_o,
    input logic [WIDTH-1:0] rd_data_o,
    input logic             rd_wr_o,
    input logic             trap_o,
    input logic             n_o,
    input logic             z_o,
    input logic             v_o,
    input logic             c_o
);
    // R4
    n_matches_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ext_en) |=> (n_o == y_o[WIDTH-1]));

    // R5
    z_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ext_en) |=> (!z_o || (y_o == '0)));

    // R7
    v_from_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ext_en && rd_idx != '0) |=> (v_o == (~rd_data_o[0] ^ y_o[WIDTH-1])));

    // R8
    no_write_idx0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ext_en && rd_idx == '0) |=> (!rd_wr_o && $stable(rd_data_o)));

    // R9
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !ext_en) |=> (trap_o && $stable(y_o) && $stable(rd_data_o)
                                  && $stable({n_o, z_o, v_o, c_o})));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> (!rd_wr_o && !trap_o && $stable(y_o) && $stable({n_o, z_o, v_o, c_o})));

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_wr_o, trap_o}));
endmodule

bind dstep_unit dstep_unit_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .ext_en    (ext_en),
    .rd_idx    (rd_idx),
    .y_o       (y_o),
    .rd_data_o (rd_data_o),
    .rd_wr_o   (rd_wr_o),
    .trap_o    (trap_o),
    .n_o       (n_o),
    .z_o       (z_o),
    .v_o       (v_o),
    .c_o       (c_o)
);

// File: tb/tb_dstep_unit.sv
module tb_dstep_unit;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0;
    logic          ext_en = 1'b1;
    logic [W-1:0]  y_in = '0, rs1_in = '0, divisor_in = '0;
    logic          n_in = 1'b0, v_in = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [W-1:0]  y_o, rd_data_o;
    logic          rd_wr_o, trap_o, n_o, z_o, v_o, c_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dstep_unit #(.WIDTH(W), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .ext_en(ext_en),
        .y_in(y_in), .rs1_in(rs1_in), .divisor_in(divisor_in),
        .n_in(n_in), .v_in(v_in), .rd_idx(rd_idx),
        .y_o(y_o), .rd_data_o(rd_data_o), .rd_wr_o(rd_wr_o), .trap_o(trap_o),
        .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o)
    );

    // expected results, taken from the requirement text
    logic [W-1:0] e_sum, e_rd;
    logic         e_n, e_z, e_v, e_c;

    task automatic expect_step(input logic [W-1:0] y, input logic [W-1:0] r1,
                               input logic [W-1:0] d, input logic n, input logic v);
        logic         s, y31, ns;
        logic [W-1:0] rem, opnd;
        s    = n ^ v;
        y31  = y[W-1];
        rem  = (y << 1) | {{(W-1){1'b0}}, r1[W-1]};
        opnd = s ? d : (0 - d);
        e_sum = rem + opnd;
        e_c  = (e_sum < rem) || (e_sum < opnd);
        e_n  = e_sum[W-1];
        e_z  = (e_sum == 0) && (s == y31);
        ns   = (s && !y31) || (!e_c && (s || !y31));
        e_v  = ns != e_sum[W-1];
        e_rd = (r1 << 1) | {{(W-1){1'b0}}, !ns};
    endtask

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one strobe at negedge, sample at next negedge
    task automatic do_step(input logic [W-1:0] y, input logic [W-1:0] r1,
                           input logic [W-1:0] d, input logic n, input logic v,
                           input logic [IW-1:0] idx, input logic ext);
        @(negedge clk);
        y_in = y; rs1_in = r1; divisor_in = d; n_in = n; v_in = v;
        rd_idx = idx; ext_en = ext; step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic chk_all(input string tag, input logic [IW-1:0] idx);
        chk("R3", {tag, " y"}, y_o, e_sum);
        chk("R4", {tag, " n"}, W'(n_o), W'(e_n));
        chk("R5", {tag, " z"}, W'(z_o), W'(e_z));
        chk("R6", {tag, " c"}, W'(c_o), W'(e_c));
        chk("R7", {tag, " v"}, W'(v_o), W'(e_v));
        if (idx != 0) begin
            chk("R8", {tag, " rd"}, rd_data_o, e_rd);
            chk("R8", {tag, " wr"}, W'(rd_wr_o), W'(1));
        end
    endtask

    task automatic t_reset();
        chk("R1", "y", y_o, '0);
        chk("R1", "rd", rd_data_o, '0);
        chk("R1", "flags", W'({n_o, z_o, v_o, c_o}), '0);
        chk("R1", "pulses", W'({rd_wr_o, trap_o}), '0);
    endtask

    task automatic t_subtract();   // R2 sign 0
        expect_step(32'h0000_0003, 32'h8000_0000, 32'h0000_0005, 1'b0, 1'b0);
        do_step(32'h0000_0003, 32'h8000_0000, 32'h0000_0005, 1'b0, 1'b0, 5'd3, 1'b1);
        chk_all("R2 sub", 5'd3);
    endtask

    task automatic t_add();        // R2 sign 1
        expect_step(32'hFFFF_FFF0, 32'h1234_5678, 32'h0000_0100, 1'b1, 1'b0);
        do_step(32'hFFFF_FFF0, 32'h1234_5678, 32'h0000_0100, 1'b1, 1'b0, 5'd7, 1'b1);
        chk_all("R2 add", 5'd7);
        expect_step(32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);
        do_step(32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 5'd31, 1'b1);
        chk_all("R6 wrap", 5'd31);
    endtask

    task automatic t_zero();       // R5 both outcomes of sign vs y31
        // sign 1, y31 1, sum wraps to zero
        expect_step(32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0);
        do_step(32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0, 5'd1, 1'b1);
        chk("R5", "z set", W'(z_o), W'(1));
        chk_all("R5 a", 5'd1);
        // sum zero but sign 0, y31 1
        expect_step(32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0);
        do_step(32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 5'd1, 1'b1);
        chk("R5", "z clear", W'(z_o), W'(0));
        chk_all("R5 b", 5'd1);
    endtask

    task automatic t_idx0();       // R8 idx zero
        logic [W-1:0] prev;
        prev = rd_data_o;
        expect_step(32'h0000_0010, 32'h4000_0000, 32'h0000_0003, 1'b0, 1'b0);
        do_step(32'h0000_0010, 32'h4000_0000, 32'h0000_0003, 1'b0, 1'b0, 5'd0, 1'b1);
        chk("R8", "idx0 no wr", W'(rd_wr_o), W'(0));
        chk("R8", "idx0 rd hold", rd_data_o, prev);
        chk("R3", "idx0 y", y_o, e_sum);
    endtask

    task automatic t_trap();       // R9
        logic [W-1:0] py, prd;
        logic [3:0]   pf;
        py = y_o; prd = rd_data_o; pf = {n_o, z_o, v_o, c_o};
        do_step(32'h1111_1111, 32'h2222_2222, 32'h3, 1'b1, 1'b1, 5'd9, 1'b0);
        chk("R9", "trap", W'(trap_o), W'(1));
        chk("R9", "wr", W'(rd_wr_o), W'(0));
        chk("R9", "y hold", y_o, py);
        chk("R9", "rd hold", rd_data_o, prd);
        chk("R9", "flags hold", W'({n_o, z_o, v_o, c_o}), W'(pf));
        @(negedge clk);
        chk("R9", "trap one cycle", W'(trap_o), W'(0));
        ext_en = 1'b1;
    endtask

    task automatic t_idle();       // R10
        logic [W-1:0] py;
        py = y_o;
        expect_step(32'h0, 32'h0, 32'h7, 1'b0, 1'b0);
        do_step(32'h0, 32'h0, 32'h7, 1'b0, 1'b0, 5'd2, 1'b1);
        py = y_o;
        y_in = 32'hDEAD_BEEF; divisor_in = 32'h1;
        repeat (3) @(negedge clk);
        chk("R10", "y hold", y_o, py);
        chk("R10", "wr low", W'(rd_wr_o), W'(0));
        chk("R10", "trap low", W'(trap_o), W'(0));
    endtask

    task automatic t_chain();      // feed outputs back, as a sequencer would
        logic [W-1:0] y, q;
        logic n, v;
        y = 32'h0; q = 32'h0000_0064; n = 1'b0; v = 1'b0;
        for (int i = 0; i < 8; i++) begin
            expect_step(y, q, 32'h0000_0007, n, v);
            do_step(y, q, 32'h0000_0007, n, v, 5'd4, 1'b1);
            chk_all("R7 chain", 5'd4);
            y = y_o; q = rd_data_o; n = n_o; v = v_o;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_subtract();
        t_add();
        t_zero();
        t_idx0();
        t_trap();
        t_idle();
        t_chain();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule